// File: doc/BRIEF.md
# Multi-Channel Timer Unit with Timestamp Counter

This unit holds three auto-reloading down-counters and one free-running 40-bit up-counting timestamp. Two of the down-counters are 16 bits wide and the third is 32 bits wide. Each can raise a level interrupt when it passes below zero. Software reaches all of them through a single-cycle register port: a write takes effect at the clock edge where `reg_we` is high, and a read is combinational from `reg_addr`.

Tick generation lies outside the unit. Two single-cycle enable strobes arrive from elsewhere: a slow tick, nominally about 508 kHz, and a fast tick, nominally about 983 kHz. Each down-counter picks one of the two. The timestamp always advances on the fast tick and never interrupts. A typical use runs one down-counter as a periodic system tick and reads the timestamp to measure time between interrupts.

The address is split in two. `reg_addr[4:3]` selects the unit: 0, 1 and 2 are the down-counters (2 is the 32-bit one), and 3 is the timestamp. `reg_addr[2:0]` selects the field.

Top module: `timer_unit`

## Requirements
- R1: After reset, every load, value and control field reads 0, all `irq` bits are 0, and the timestamp reads 0 with its enable off.
- R2: A write to a counter's load field (field 0) stores the data truncated to the counter's width (16 bits for units 0 and 1, 32 bits for unit 2). The value field (field 1) reads the same data in the next cycle, and this holds whether or not the counter is enabled.
- R3: A counter whose control bit 7 is 1 decrements by one on each selected tick. With bit 7 at 0, its value does not change.
- R4: Control bit 3 set to 1 selects the slow tick as the count enable. Bit 3 at 0 selects the fast tick. The tick that is not selected has no effect.
- R5: With control bit 6 set to 1 (periodic), a counter at zero reloads from its load field on the next tick. Loading N-1 therefore gives one underflow every N ticks.
- R6: With control bit 6 at 0 (free-run), a counter at zero wraps to all ones on the next tick: 0xFFFF for the 16-bit units and 0xFFFFFFFF for the 32-bit unit.
- R7: An underflow sets that counter's `irq` bit, and the bit stays high until it is cleared. Each counter drives only its own bit: `irq[k]` belongs to unit k.
- R8: Any write to a counter's clear field (field 3) drops that counter's `irq` bit, whatever the data. If an underflow happens in the same cycle as the clear, the bit stays high.
- R9: With bit 8 of the timestamp high word (unit 3, field 1) set, the 40-bit timestamp increments on each fast tick. The slow tick does not move it. Field 0 reads bits 31:0, and the high word reads bits 39:32 in its bits 7:0 with the enable in bit 8.
- R10: With its enable off, the timestamp holds its count. Writes to the timestamp low word do not change it.
- R11: The control field reads back only bits 7, 6 and 3 of what was written. Reads of clear fields, of fields 4 to 7 and of unit 3 fields other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Single-cycle slow count strobe |
| fast_tick | input | 1 | Single-cycle fast count strobe |
| reg_addr | input | 5 | Register address: unit in bits 4:3, field in bits 2:0 |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 3 | Level interrupt per down-counter, bit k for unit k |

## Verification
The assertions assume that each tick strobe is a clean single-cycle pulse sampled at the rising edge. They also assume that a write lasts exactly one cycle. A clear therefore counts as winning only when neither tick is high in that cycle, and an interrupt may rise only in a cycle that follows a tick. The stimulus holds each strobe and each write for exactly one edge and changes inputs one time unit after the edge. It raises a tick together with a clear only in the one case built to test underflow priority, and it never runs the timestamp long enough to reach the carry into the high word.

// File: rtl/timer_unit.sv
`timescale 1ns/1ps
module timer_unit #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int TS_W     = 40,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [2:0]        irq
);
  localparam int NCNT      = 3;
  localparam int TS_HI_W   = TS_W - DATA_W;
  localparam int TS_EN_BIT = 8;
  localparam logic [2:0] F_LOAD = 3'd0, F_VAL = 3'd1, F_CTRL = 3'd2, F_CLR = 3'd3;
  localparam logic [1:0] TS_UNIT = 2'd3;

  wire [1:0] unit = reg_addr[4:3];
  wire [2:0] fld  = reg_addr[2:0];

  logic [DATA_W-1:0] load_rd  [NCNT];
  logic [DATA_W-1:0] value_rd [NCNT];
  logic [7:0]        ctrl_rd  [NCNT];

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam int W = (g == NCNT-1) ? WIDE_W : NARROW_W;
    logic [W-1:0] load_q, val_q;
    logic en_q, per_q, slow_sel_q, irq_q;
    wire sel     = reg_we && (unit == 2'(g));
    wire tick    = en_q && (slow_sel_q ? slow_tick : fast_tick);
    wire at_zero = (val_q == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        load_q <= '0; val_q <= '0;
        en_q <= 1'b0; per_q <= 1'b0; slow_sel_q <= 1'b0; irq_q <= 1'b0;
      end else begin
        if (sel && fld == F_CTRL)
          {en_q, per_q, slow_sel_q} <= {reg_wdata[7], reg_wdata[6], reg_wdata[3]};
        if (sel && fld == F_LOAD) begin
          load_q <= reg_wdata[W-1:0];
          val_q  <= reg_wdata[W-1:0];
        end else if (tick) begin
          val_q <= at_zero ? (per_q ? load_q : '1) : val_q - 1'b1;
        end
        if (tick && at_zero)           irq_q <= 1'b1;
        else if (sel && fld == F_CLR)  irq_q <= 1'b0;
      end
    end

    assign irq[g]      = irq_q;
    assign load_rd[g]  = DATA_W'(load_q);
    assign value_rd[g] = DATA_W'(val_q);
    assign ctrl_rd[g]  = {en_q, per_q, 2'b00, slow_sel_q, 3'b000};
  end

  logic [TS_W-1:0] ts_q;
  logic            ts_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q <= '0; ts_en_q <= 1'b0;
    end else begin
      if (reg_we && unit == TS_UNIT && fld == F_VAL) ts_en_q <= reg_wdata[TS_EN_BIT];
      if (ts_en_q && fast_tick) ts_q <= ts_q + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (unit == TS_UNIT) begin
      if (fld == 3'd0) reg_rdata = ts_q[DATA_W-1:0];
      else if (fld == 3'd1) begin
        reg_rdata[TS_HI_W-1:0] = ts_q[TS_W-1:DATA_W];
        reg_rdata[TS_EN_BIT]   = ts_en_q;
      end
    end else begin
      case (fld)
        F_LOAD:  reg_rdata = load_rd[unit];
        F_VAL:   reg_rdata = value_rd[unit];
        F_CTRL:  reg_rdata[7:0] = ctrl_rd[unit];
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

module timer_unit_chk #(
  parameter int TS_W   = 40,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slow_tick,
  input logic              fast_tick,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [2:0]        irq,
  input logic [TS_W-1:0]   ts_val,
  input logic              ts_on
);
  a_r1_reset_irq: assert property (@(posedge clk) !rst_n |=> (irq == 3'b000));

  for (genvar i = 0; i < 3; i++) begin : g_irq
    wire clr_hit = reg_we && (reg_addr[4:3] == 2'(i)) && (reg_addr[2:0] == 3'd3);
    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] && !clr_hit |=> irq[i]);
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit && !slow_tick && !fast_tick |=> !irq[i]);
    a_r7_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(slow_tick || fast_tick));
  end

  a_r9_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
    ts_on && fast_tick |=> ts_val == $past(ts_val) + 1'b1);
  a_r10_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ts_on && fast_tick) |=> $stable(ts_val));
endmodule

bind timer_unit timer_unit_chk #(.TS_W(TS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
  .reg_addr(reg_addr), .reg_we(reg_we), .irq(irq), .ts_val(ts_q), .ts_on(ts_en_q)
);

// File: tb/timer_unit_tb.sv
`timescale 1ns/1ps
module timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0, fast_tick = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .reg_addr(addr), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic        kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  item_t it;
  logic [31:0] act;
  int checks = 0, fails = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      it = q.pop_front();
      act = it.kind ? {29'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string r);
    addr = a;
    q.push_back('{1'b0, e, r});
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string r);
    q.push_back('{1'b1, {29'b0, e}, r});
    @(posedge clk); #1;
  endtask

  task automatic slow(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1; @(posedge clk); #1; slow_tick = 1'b0;
    end
  endtask

  task automatic fast(input int n);
    for (int i = 0; i < n; i++) begin
      fast_tick = 1'b1; @(posedge clk); #1; fast_tick = 1'b0;
    end
  endtask

  task automatic clr_with_slow(input logic [4:0] a);
    addr = a; wdata = 32'h0; we = 1'b1; slow_tick = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; slow_tick = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    rd(5'd1,  32'h0, "R1 unit0 value");
    rd(5'd9,  32'h0, "R1 unit1 value");
    rd(5'd17, 32'h0, "R1 unit2 value");
    rd(5'd2,  32'h0, "R1 unit0 ctrl");
    rd(5'd24, 32'h0, "R1 ts low");
    rd(5'd25, 32'h0, "R1 ts high");
    chk_irq(3'b000, "R1 irq");

    wr(5'd0, 32'h12345);
    rd(5'd1, 32'h2345, "R2 value truncated");
    rd(5'd0, 32'h2345, "R2 load truncated");
    wr(5'd16, 32'hDEADBEEF);
    rd(5'd17, 32'hDEADBEEF, "R2 wide value");

    wr(5'd2, 32'hFF);
    rd(5'd2, 32'hC8, "R11 ctrl readback");
    wr(5'd2, 32'h48);
    rd(5'd2, 32'h48, "R11 ctrl stopped");
    rd(5'd3, 32'h0, "R11 clear reads zero");
    rd(5'd4, 32'h0, "R11 unmapped field");
    rd(5'd26, 32'h0, "R11 unmapped ts field");

    slow(2);
    rd(5'd1, 32'h2345, "R3 disabled holds");
    rd(5'd17, 32'hDEADBEEF, "R3 unit2 disabled holds");

    wr(5'd0, 32'h3);
    wr(5'd2, 32'hC8);
    slow(1);
    rd(5'd1, 32'h2, "R3 decrement");
    fast(2);
    rd(5'd1, 32'h2, "R4 unselected fast ignored");
    slow(2);
    rd(5'd1, 32'h0, "R5 reached zero");
    chk_irq(3'b000, "R7 no irq before underflow");
    slow(1);
    rd(5'd1, 32'h3, "R5 reload after N ticks");
    chk_irq(3'b001, "R7 irq on underflow");
    chk_irq(3'b001, "R7 irq level held");

    wr(5'd3, 32'h0);
    chk_irq(3'b000, "R8 clear");
    slow(3);
    chk_irq(3'b000, "R8 stays clear");
    clr_with_slow(5'd3);
    chk_irq(3'b001, "R8 underflow wins over clear");
    rd(5'd1, 32'h3, "R5 second reload");
    wr(5'd3, 32'h55);
    chk_irq(3'b000, "R8 any data clears");
    wr(5'd2, 32'h48);

    wr(5'd8, 32'h5);
    wr(5'd10, 32'hC0);
    slow(2);
    rd(5'd9, 32'h5, "R4 slow ignored on fast-select");
    fast(2);
    rd(5'd9, 32'h3, "R4 fast counts");
    wr(5'd8, 32'h9);
    rd(5'd9, 32'h9, "R2 load while enabled");
    wr(5'd8, 32'h3);

    wr(5'd10, 32'h80);
    fast(4);
    rd(5'd9, 32'hFFFF, "R6 narrow wrap");
    chk_irq(3'b010, "R7 irq unit1");
    wr(5'd11, 32'h0);
    chk_irq(3'b000, "R8 clear unit1");
    wr(5'd10, 32'h0);

    wr(5'd16, 32'h1);
    wr(5'd18, 32'h88);
    slow(2);
    rd(5'd17, 32'hFFFFFFFF, "R6 wide wrap");
    chk_irq(3'b100, "R7 irq unit2");
    slow(1);
    rd(5'd17, 32'hFFFFFFFE, "R6 free-run continues");
    wr(5'd18, 32'h0);
    wr(5'd19, 32'h0);
    chk_irq(3'b000, "R8 clear unit2");

    fast(3);
    rd(5'd24, 32'h0, "R10 ts disabled");
    wr(5'd25, 32'h100);
    rd(5'd25, 32'h100, "R9 ts enable readback");
    fast(5);
    rd(5'd24, 32'h5, "R9 ts counts fast");
    slow(3);
    rd(5'd24, 32'h5, "R9 ts ignores slow");
    wr(5'd24, 32'hFFFF);
    rd(5'd24, 32'h5, "R10 low write ignored");
    wr(5'd25, 32'h0);
    fast(2);
    rd(5'd24, 32'h5, "R10 ts holds when off");
    rd(5'd25, 32'h0, "R10 ts high off");
    chk_irq(3'b000, "R10 ts never interrupts");

    @(posedge clk); #1;
    done = 1;
    summary();
    $finish;
  end
endmodule